// File: doc/BRIEF.md
# Dual-Issue Pairing Interlock

This block is the issue-stage interlock of an in-order processor with two execution pipelines, A and B. Each cycle it looks at two decoded instructions. The older one sits in slot 0 and is always routed to pipeline A. The younger one sits in slot 1 and is routed to pipeline B. The block decides whether both may issue together. If they may not, only the older one issues and pipeline B receives a bubble. The decode stage is told through `issue_b` that slot 1 was not consumed. It then presents that instruction again as slot 0 on the next cycle, so program order is kept and no instruction is swapped past another.

The pipelines are asymmetric. Pipeline A holds the only multiplier and the only divider. Both are multi-cycle units. When one of them accepts an instruction, the whole issue stage is frozen until the unit finishes, and this freeze also covers the partner that issued in the same cycle. Every cycle in which a valid older instruction waits, or a younger one is held back, adds one to a saturating stall counter. Software can read that counter and clear it.

Top module: `dual_issue_interlock`

## Requirements
- R1: After reset, `stall_count` is 0 and `mul_busy` and `div_busy` are low.
- R2: When slot 0 is valid, no unit is busy, and slot 1 is valid, single-cycle and independent, both `issue_a` and `issue_b` are high in the same cycle.
- R3: Class encoding: 0 is ALU, 1 is MUL, 2 is DIV, and 3 is another single-cycle class. When slot 1 is MUL or DIV, `issue_b` is low and only slot 0 issues. This includes the case of two multiplies.
- R4: When either source of slot 1 equals the destination of slot 0, `issue_b` is low and only slot 0 issues.
- R5: A slot-1 instruction that was held back and is presented again as slot 0 on the next cycle issues in that cycle, provided no unit is busy.
- R6: After a DIV issues in pipeline A, `div_busy` stays high for exactly DIV_CYC-1 cycles. Nothing issues in either pipeline while it is high.
- R7: After a MUL issues in pipeline A, `mul_busy` stays high for exactly MUL_CYC-1 cycles. Nothing issues while it is high.
- R8: `stall` is high when slot 0 is valid and either a unit is busy, or slot 1 is valid and is refused. Each such cycle adds one to `stall_count`.
- R9: `stall_count` holds at its all-ones value instead of wrapping.
- R10: `stall_clr` sets `stall_count` to 0 on the next edge, and it takes priority over a stall in the same cycle.
- R11: When slot 0 is not valid, neither pipeline issues and no stall is counted, whatever slot 1 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Older instruction present |
| s0_cls | input | 2 | Older instruction class |
| s0_dst | input | REG_W | Older instruction destination register |
| s1_valid | input | 1 | Younger instruction present |
| s1_cls | input | 2 | Younger instruction class |
| s1_src1 | input | REG_W | Younger instruction first source register |
| s1_src2 | input | REG_W | Younger instruction second source register |
| stall_clr | input | 1 | Synchronous clear of the stall counter |
| issue_a | output | 1 | Slot 0 issues to pipeline A |
| issue_b | output | 1 | Slot 1 issues to pipeline B (low means a bubble) |
| stall | output | 1 | A stall cycle is being inserted |
| mul_busy | output | 1 | Multiplier occupied |
| div_busy | output | 1 | Divider occupied |
| stall_count | output | CNT_W | Saturating count of stall cycles |

## Verification
The bench aims at pair refusals that look alike.

- A multiply or divide in slot 1 must be refused (R3). A design that let it through would issue it to pipeline B, which has no such unit.
- A read of slot 0's destination through the second source must also be refused (R4). A design that compared only the first source would pair a dependent instruction.
- The busy window is checked cycle by cycle after both multiplies and divides. An off-by-one window would let the next instruction issue while the result is still pending, or it would add a stall that is not needed.
- The counter is driven past its all-ones value. A wrap to zero shows up at once.
- A clear is applied in a cycle that is also a stall, which shows whether the clear wins.

// File: rtl/dual_issue_interlock.sv
module dual_issue_interlock #(
  parameter int REG_W   = 5,
  parameter int DIV_CYC = 8,
  parameter int MUL_CYC = 2,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_valid,
  input  logic [1:0]       s0_cls,
  input  logic [REG_W-1:0] s0_dst,
  input  logic             s1_valid,
  input  logic [1:0]       s1_cls,
  input  logic [REG_W-1:0] s1_src1,
  input  logic [REG_W-1:0] s1_src2,
  input  logic             stall_clr,
  output logic             issue_a,
  output logic             issue_b,
  output logic             stall,
  output logic             mul_busy,
  output logic             div_busy,
  output logic [CNT_W-1:0] stall_count
);
  localparam int LONGEST = (DIV_CYC > MUL_CYC) ? DIV_CYC : MUL_CYC;
  localparam int BW = $clog2(LONGEST) + 1;
  localparam logic [1:0] CL_MUL = 2'd1;
  localparam logic [1:0] CL_DIV = 2'd2;
  localparam logic [BW-1:0] DIV_LD = BW'(DIV_CYC - 1);
  localparam logic [BW-1:0] MUL_LD = BW'(MUL_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [BW-1:0] busy_q;
  logic          busy_div_q;
  logic          busy, s1_long, s1_raw, refuse;

  assign busy     = busy_q != '0;
  assign s1_long  = (s1_cls == CL_MUL) || (s1_cls == CL_DIV);
  assign s1_raw   = (s1_src1 == s0_dst) || (s1_src2 == s0_dst);
  assign refuse   = s1_valid && (s1_long || s1_raw);

  assign issue_a  = s0_valid && !busy;
  assign issue_b  = issue_a && s1_valid && !s1_long && !s1_raw;
  assign stall    = s0_valid && (busy || refuse);
  assign mul_busy = busy && !busy_div_q;
  assign div_busy = busy && busy_div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= '0;
      busy_div_q <= 1'b0;
    end else if (busy) begin
      busy_q <= busy_q - 1'b1;
    end else if (issue_a && s0_cls == CL_DIV) begin
      busy_q     <= DIV_LD;
      busy_div_q <= 1'b1;
    end else if (issue_a && s0_cls == CL_MUL) begin
      busy_q     <= MUL_LD;
      busy_div_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stall_clr)
      stall_count <= '0;
    else if (stall && stall_count != CNT_MAX)
      stall_count <= stall_count + 1'b1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (stall_count == '0 && !mul_busy && !div_busy));
  a_r3_b_pipe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    issue_b |-> (issue_a && s1_cls != CL_MUL && s1_cls != CL_DIV));
  a_r4_no_dependent_pair: assert property (@(posedge clk) disable iff (!rst_n)
    issue_b |-> (s1_src1 != s0_dst && s1_src2 != s0_dst));
  a_r6_div_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV_CYC > 1 && issue_a && s0_cls == CL_DIV) |=> div_busy);
  a_r7_mul_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (MUL_CYC > 1 && issue_a && s0_cls == CL_MUL) |=> mul_busy);
  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_busy || div_busy) |-> (!issue_a && !issue_b));
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !stall_clr && stall_count != CNT_MAX) |=> stall_count == $past(stall_count) + 1'b1);
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_count == CNT_MAX && !stall_clr) |=> stall_count == CNT_MAX);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stall_clr |=> stall_count == '0);
  a_r11_no_issue_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_valid |-> (!issue_a && !issue_b && !stall));
endmodule

// File: tb/sim_dual_issue_interlock.sv
module sim_dual_issue_interlock;
  localparam int REG_W = 5, DIV_CYC = 8, MUL_CYC = 2, CNT_W = 6;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic s0_valid = 0, s1_valid = 0, stall_clr = 0;
  logic [1:0] s0_cls = 0, s1_cls = 0;
  logic [REG_W-1:0] s0_dst = 0, s1_src1 = 0, s1_src2 = 0;
  logic issue_a, issue_b, stall, mul_busy, div_busy;
  logic [CNT_W-1:0] stall_count;

  int checks = 0, errors = 0;
  int m_busy = 0;
  bit m_div = 0;
  int m_cnt = 0;

  dual_issue_interlock #(.REG_W(REG_W), .DIV_CYC(DIV_CYC), .MUL_CYC(MUL_CYC), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_dst(s0_dst),
    .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_src1(s1_src1), .s1_src2(s1_src2),
    .stall_clr(stall_clr), .issue_a(issue_a), .issue_b(issue_b), .stall(stall),
    .mul_busy(mul_busy), .div_busy(div_busy), .stall_count(stall_count));

  always #4 clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_long(logic [1:0] c);
    return c == 2'd1 || c == 2'd2;
  endfunction

  task automatic step(string tag, bit v0, logic [1:0] c0, int d0,
                      bit v1, logic [1:0] c1, int a1, int b1, bit clr);
    bit ea, eb, es, rf;
    @(negedge clk);
    s0_valid = v0; s0_cls = c0; s0_dst = REG_W'(d0);
    s1_valid = v1; s1_cls = c1; s1_src1 = REG_W'(a1); s1_src2 = REG_W'(b1);
    stall_clr = clr;
    #1;
    rf = v1 && (exp_long(c1) || a1 == d0 || b1 == d0);
    ea = v0 && m_busy == 0;
    eb = ea && v1 && !rf;
    es = v0 && (m_busy != 0 || rf);
    chk(tag, "issue_a", int'(issue_a), int'(ea));
    chk(tag, "issue_b", int'(issue_b), int'(eb));
    chk(tag, "stall", int'(stall), int'(es));
    chk(tag, "mul_busy", int'(mul_busy), int'(m_busy != 0 && !m_div));
    chk(tag, "div_busy", int'(div_busy), int'(m_busy != 0 && m_div));
    chk(tag, "stall_count", int'(stall_count), m_cnt);
    if (m_busy != 0) m_busy--;
    else if (ea && c0 == 2'd2) begin m_busy = DIV_CYC - 1; m_div = 1; end
    else if (ea && c0 == 2'd1) begin m_busy = MUL_CYC - 1; m_div = 0; end
    if (clr) m_cnt = 0;
    else if (es && m_cnt != CMAX) m_cnt++;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", "stall_count", int'(stall_count), 0);
    chk("R1", "mul_busy", int'(mul_busy), 0);
    chk("R1", "div_busy", int'(div_busy), 0);
    @(negedge clk); rst_n = 1;

    step("R11", 0, 2'd0, 1, 1, 2'd0, 2, 3, 0);
    step("R11", 0, 2'd2, 1, 1, 2'd1, 1, 1, 0);
    step("R2", 1, 2'd0, 3, 1, 2'd0, 1, 2, 0);
    step("R2", 1, 2'd3, 7, 1, 2'd3, 6, 0, 0);
    step("R3", 1, 2'd0, 3, 1, 2'd1, 1, 2, 0);
    step("R5", 1, 2'd1, 4, 1, 2'd0, 1, 2, 0);
    step("R7", 1, 2'd0, 2, 1, 2'd0, 5, 6, 0);
    step("R7", 1, 2'd0, 2, 1, 2'd0, 5, 6, 0);
    step("R4", 1, 2'd0, 5, 1, 2'd0, 5, 1, 0);
    step("R5", 1, 2'd0, 6, 0, 2'd0, 0, 0, 0);
    step("R4", 1, 2'd3, 9, 1, 2'd0, 1, 9, 0);
    step("R3", 1, 2'd1, 1, 1, 2'd1, 2, 3, 0);
    for (int i = 0; i < MUL_CYC; i++) step("R7", 1, 2'd1, 1, 0, 2'd0, 0, 0, 0);
    for (int i = 0; i < MUL_CYC; i++) step("R7", 1, 2'd0, 1, 0, 2'd0, 0, 0, 0);
    step("R3", 1, 2'd0, 1, 1, 2'd2, 2, 3, 0);
    step("R6", 1, 2'd2, 4, 1, 2'd0, 1, 2, 0);
    for (int i = 0; i < DIV_CYC; i++) step("R6", 1, 2'd0, 8, 1, 2'd0, 1, 2, 0);
    step("R10", 1, 2'd0, 3, 1, 2'd1, 1, 2, 1);
    step("R10", 0, 2'd0, 0, 0, 2'd0, 0, 0, 0);
    for (int i = 0; i < CMAX + 8; i++) step("R9", 1, 2'd0, 3, 1, 2'd1, 1, 2, 0);
    step("R9", 0, 2'd0, 0, 0, 2'd0, 0, 0, 0);
    step("R10", 1, 2'd0, 3, 1, 2'd1, 1, 2, 1);
    step("R10", 0, 2'd0, 0, 0, 2'd0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      step("R2/R3/R4/R8 random",
           $urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), $urandom_range(0, 7),
           $urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
           $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 60) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule